// File: doc/BRIEF.md
# Multi-Format Video Pixel Output Formatter

This block sits after a sample-rate stage in a video decoder and turns its pixel stream into a registered parallel output bus. The upstream stage supplies one pixel per strobe. The strobe may arrive at an irregular cadence, because rate conversion decides when a pixel is ready. Alongside each pixel come a start-of-line flag, a start-of-field flag and the field identity. The block counts strobes within a line and counts lines within a field. It compares those positions with four programmable blanking limits. From that comparison it decides whether each pixel is active or blanking.

The output bus has four formats. Two-byte YCbCr 4:2:2 places luma in the upper byte and alternating chroma in the lower byte. Two RGB packings pack the colour channels into 16 or 15 bits. The fourth format is a byte-serial stream in which each strobe carries one byte. That stream embeds four-byte end-of-active and start-of-active timing codes. In all formats, blanking samples carry black level. Line, field and blanking flags and a data-valid output are registered together with the data. A format change waits for the next line, so no line mixes two formats.

Top module: `vid_out_fmt`

## Requirements
- R1: Format 0 (two-byte YCbCr): on an active pixel the output is {Y, C}. C is Cb at h == hbe_i and toggles Cr, Cb, Cr... on each further valid pixel, so it is Cr whenever (h - hbe_i) is odd.
- R2: Format 1 (RGB 5-6-5) outputs {R[7:3], G[7:2], B[7:3]} on active pixels. Format 2 (RGB 5-5-5) outputs {1'b0, R[7:3], G[7:3], B[7:3]}.
- R3: Format 3 (byte stream): bits 15:8 of the output are zero. Active bytes follow Cb, Y, Cr, Y by (h - hbe_i) mod 4, so a Cb byte always opens the active region.
- R4: Format 3 places code bytes 0xFF, 0x00, 0x00, S at h = hbs_i..hbs_i+3 (end code, H = 1) and at h = hbe_i-4..hbe_i-1 (start code, H = 0). These codes appear on every line. S is {1, F, V, H, V^H, F^H, F^V, F^V^H}, where F is the field input and V is the line's vertical blanking.
- R5: On blanking pixels, format 0 outputs 0x1080, formats 1 and 2 output 0x0000, and format 3 outputs non-code bytes 0x80 at even h and 0x10 at odd h.
- R6: h is 0 on a valid pixel with in_sol high and rises by 1 per valid pixel. Horizontal blanking is h >= hbs_i or h < hbe_i. The line count is 0 on a valid pixel with in_sol and in_sof both high, and rises by 1 on each other valid in_sol. Vertical blanking is line >= vbs_i or line < vbe_i. For each valid pixel, hsync_o, vsync_o, blank_o and field_o give horizontal blanking, vertical blanking, their OR, and in_field. Flags asserted without in_vld are ignored.
- R7: dvalid_o is high exactly in the cycle after a cycle with in_vld high. After a cycle without in_vld, every other output holds its value.
- R8: The format is sampled from fmt_i only on a valid pixel with in_sol high. fmt_i at any other time has no effect.
- R9: Synchronous reset gives pix_o = 0x1080, blank_o = 1, and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (the double-rate clock in format 3) |
| rst | input | 1 | Synchronous reset, active high |
| fmt_i | input | 2 | Requested output format, 0..3 |
| hbs_i | input | HW | Horizontal blank start count |
| hbe_i | input | HW | Horizontal blank end count (first active pixel) |
| vbs_i | input | VW | Vertical blank start line |
| vbe_i | input | VW | Vertical blank end line |
| in_vld | input | 1 | Pixel strobe from the rate stage |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First line of a field |
| in_field | input | 1 | Field identity |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference sample |
| in_cr | input | 8 | Red-difference sample |
| in_r | input | 8 | Red sample |
| in_g | input | 8 | Green sample |
| in_b | input | 8 | Blue sample |
| pix_o | output | 16 | Formatted output word |
| blank_o | output | 1 | Blanking flag |
| hsync_o | output | 1 | Horizontal blanking flag |
| vsync_o | output | 1 | Vertical blanking flag |
| field_o | output | 1 | Field flag |
| dvalid_o | output | 1 | Output word valid |

## Verification
The assertions assume that the limits keep 4 <= hbe_i < hbs_i and vbe_i < vbs_i, and that they do not change while pixels flow. They also assume that every line starts with a valid pixel that carries in_sol. The bench holds one small geometry fixed: lines of 28 pixels with limits 8 and 24, and fields of 5 lines with limits 1 and 4. It sweeps every format over two fields, with strobe gaps inserted by an arithmetic pattern. During gaps it drives stray line, field and format values, which the block must ignore.

// File: rtl/vof_pkg.sv
package vof_pkg;

    typedef enum logic [1:0] {
        FMT_YC16  = 2'd0,
        FMT_RGB16 = 2'd1,
        FMT_RGB15 = 2'd2,
        FMT_BYTE  = 2'd3
    } fmt_e;

    localparam logic [7:0] BLK_LUMA   = 8'h10;
    localparam logic [7:0] BLK_CHROMA = 8'h80;
    localparam logic [7:0] CODE_LEAD  = 8'hFF;
    localparam logic [7:0] CODE_ZERO  = 8'h00;

    typedef struct packed {
        logic [15:0] pix;
        logic        blank;
        logic        hsync;
        logic        vsync;
        logic        field;
        logic        dvalid;
        fmt_e        mode;
    } ostate_s;

    // timing-code status byte with protection bits
    function automatic logic [7:0] code_status(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vof_pos.sv
module vof_pos #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld,
    input  logic          sol,
    input  logic          sof,
    input  logic [HW-1:0] hbs,
    input  logic [HW-1:0] hbe,
    input  logic [VW-1:0] vbs,
    input  logic [VW-1:0] vbe,
    output logic          hblank,
    output logic          vblank,
    output logic          in_eav,
    output logic          in_sav,
    output logic [1:0]    code_idx,
    output logic [1:0]    act_ph,
    output logic          h_odd
);

    localparam logic [HW-1:0] HMAX = '1;
    localparam logic [HW:0]   CODE_LEN = (HW+1)'(4);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_s;

    pos_s          pos_q, pos_d;
    logic [HW-1:0] h_cur;
    logic [VW-1:0] v_cur;

    always_comb begin
        h_cur = sol ? '0 : pos_q.h;
        if (sol && sof)
            v_cur = '0;
        else if (sol)
            v_cur = pos_q.v + 1'b1;
        else
            v_cur = pos_q.v;

        hblank   = (h_cur >= hbs) || (h_cur < hbe);
        vblank   = (v_cur >= vbs) || (v_cur < vbe);
        in_eav   = (h_cur >= hbs) && ({1'b0, h_cur} < ({1'b0, hbs} + CODE_LEN));
        in_sav   = (h_cur < hbe) && (({1'b0, h_cur} + CODE_LEN) >= {1'b0, hbe});
        act_ph   = h_cur[1:0] - hbe[1:0];
        code_idx = in_eav ? (h_cur[1:0] - hbs[1:0]) : act_ph;
        h_odd    = h_cur[0];

        pos_d = pos_q;
        if (vld) begin
            pos_d.h = (h_cur == HMAX) ? h_cur : h_cur + 1'b1;
            pos_d.v = v_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else
            pos_q <= pos_d;
    end

endmodule

// File: rtl/vof_pack.sv
module vof_pack
    import vof_pkg::*;
(
    input  fmt_e        fmt,
    input  logic        act,
    input  logic        in_eav,
    input  logic        in_sav,
    input  logic [1:0]  code_idx,
    input  logic [1:0]  act_ph,
    input  logic        h_odd,
    input  logic        field,
    input  logic        vblank,
    input  logic [7:0]  y,
    input  logic [7:0]  cb,
    input  logic [7:0]  cr,
    input  logic [7:0]  r,
    input  logic [7:0]  g,
    input  logic [7:0]  b,
    output logic [15:0] word
);

    logic [7:0] byte_val;

    always_comb begin
        if (in_eav || in_sav) begin
            case (code_idx)
                2'd0:    byte_val = CODE_LEAD;
                2'd3:    byte_val = code_status(field, vblank, in_eav);
                default: byte_val = CODE_ZERO;
            endcase
        end else if (act) begin
            case (act_ph)
                2'd0:    byte_val = cb;
                2'd2:    byte_val = cr;
                default: byte_val = y;
            endcase
        end else begin
            byte_val = h_odd ? BLK_LUMA : BLK_CHROMA;
        end

        case (fmt)
            FMT_YC16:  word = act ? {y, (act_ph[0] ? cr : cb)} : {BLK_LUMA, BLK_CHROMA};
            FMT_RGB16: word = act ? {r[7:3], g[7:2], b[7:3]} : 16'h0000;
            FMT_RGB15: word = act ? {1'b0, r[7:3], g[7:3], b[7:3]} : 16'h0000;
            default:   word = {8'h00, byte_val};
        endcase
    end

endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
    import vof_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    fmt_i,
    input  logic [HW-1:0] hbs_i,
    input  logic [HW-1:0] hbe_i,
    input  logic [VW-1:0] vbs_i,
    input  logic [VW-1:0] vbe_i,
    input  logic          in_vld,
    input  logic          in_sol,
    input  logic          in_sof,
    input  logic          in_field,
    input  logic [7:0]    in_y,
    input  logic [7:0]    in_cb,
    input  logic [7:0]    in_cr,
    input  logic [7:0]    in_r,
    input  logic [7:0]    in_g,
    input  logic [7:0]    in_b,
    output logic [15:0]   pix_o,
    output logic          blank_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          field_o,
    output logic          dvalid_o
);

    ostate_s    st_q, st_d;
    fmt_e       fmt_eff;
    logic       hblank, vblank, in_eav, in_sav, h_odd;
    logic [1:0] code_idx, act_ph;
    logic [15:0] word;

    vof_pos #(.HW(HW), .VW(VW)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .vld      (in_vld),
        .sol      (in_sol),
        .sof      (in_sof),
        .hbs      (hbs_i),
        .hbe      (hbe_i),
        .vbs      (vbs_i),
        .vbe      (vbe_i),
        .hblank   (hblank),
        .vblank   (vblank),
        .in_eav   (in_eav),
        .in_sav   (in_sav),
        .code_idx (code_idx),
        .act_ph   (act_ph),
        .h_odd    (h_odd)
    );

    vof_pack u_pack (
        .fmt      (fmt_eff),
        .act      (!hblank && !vblank),
        .in_eav   (in_eav),
        .in_sav   (in_sav),
        .code_idx (code_idx),
        .act_ph   (act_ph),
        .h_odd    (h_odd),
        .field    (in_field),
        .vblank   (vblank),
        .y        (in_y),
        .cb       (in_cb),
        .cr       (in_cr),
        .r        (in_r),
        .g        (in_g),
        .b        (in_b),
        .word     (word)
    );

    always_comb begin
        fmt_eff   = (in_vld && in_sol) ? fmt_e'(fmt_i) : st_q.mode;
        st_d        = st_q;
        st_d.dvalid = 1'b0;
        if (in_vld) begin
            st_d.mode   = fmt_eff;
            st_d.pix    = word;
            st_d.blank  = hblank || vblank;
            st_d.hsync  = hblank;
            st_d.vsync  = vblank;
            st_d.field  = in_field;
            st_d.dvalid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pix    <= {BLK_LUMA, BLK_CHROMA};
            st_q.blank  <= 1'b1;
            st_q.hsync  <= 1'b0;
            st_q.vsync  <= 1'b0;
            st_q.field  <= 1'b0;
            st_q.dvalid <= 1'b0;
            st_q.mode   <= FMT_YC16;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o    = st_q.pix;
    assign blank_o  = st_q.blank;
    assign hsync_o  = st_q.hsync;
    assign vsync_o  = st_q.vsync;
    assign field_o  = st_q.field;
    assign dvalid_o = st_q.dvalid;

endmodule

// File: rtl/vof_chk.sv
module vof_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_vld,
    input logic        in_sol,
    input logic [15:0] pix_o,
    input logic        blank_o,
    input logic        hsync_o,
    input logic        vsync_o,
    input logic        dvalid_o,
    input logic [1:0]  mode
);

    assert_dvalid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> dvalid_o);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!dvalid_o && $stable(pix_o) && $stable(blank_o) && $stable(hsync_o) && $stable(vsync_o)));

    assert_blank_or_R6: assert property (@(posedge clk) disable iff (rst)
        dvalid_o |-> (blank_o == (hsync_o || vsync_o)));

    assert_mode_line_R8: assert property (@(posedge clk) disable iff (rst)
        !(in_vld && in_sol) |=> $stable(mode));

    assert_byte_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (dvalid_o && mode == 2'd3) |-> (pix_o[15:8] == 8'h00));

    assert_yc_blank_R5: assert property (@(posedge clk) disable iff (rst)
        (dvalid_o && blank_o && mode == 2'd0) |-> (pix_o == 16'h1080));

endmodule

bind vid_out_fmt vof_chk u_vof_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_sol   (in_sol),
    .pix_o    (pix_o),
    .blank_o  (blank_o),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .dvalid_o (dvalid_o),
    .mode     (st_q.mode)
);

// File: tb/tb_vid_out_fmt.sv
module tb_vid_out_fmt;

    localparam int CLK_PERIOD = 10;
    localparam int HW   = 12;
    localparam int VW   = 11;
    localparam int HBE  = 8;
    localparam int HBS  = 24;
    localparam int HLEN = 28;
    localparam int VBE  = 1;
    localparam int VBS  = 4;
    localparam int VLEN = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    fmt_i;
    logic          in_vld, in_sol, in_sof, in_field;
    logic [7:0]    in_y, in_cb, in_cr, in_r, in_g, in_b;
    logic [15:0]   pix_o;
    logic          blank_o, hsync_o, vsync_o, field_o, dvalid_o;

    int total = 0;
    int bad   = 0;
    logic [15:0] last_pix;
    logic        last_blank;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_out_fmt #(.HW(HW), .VW(VW)) dut (
        .clk(clk), .rst(rst), .fmt_i(fmt_i),
        .hbs_i(HW'(HBS)), .hbe_i(HW'(HBE)), .vbs_i(VW'(VBS)), .vbe_i(VW'(VBE)),
        .in_vld(in_vld), .in_sol(in_sol), .in_sof(in_sof), .in_field(in_field),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .pix_o(pix_o), .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .field_o(field_o), .dvalid_o(dvalid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sy(int h, int v, int f);  return 8'((h*13 + v*29 + f*7 + 3) % 256);   endfunction
    function automatic logic [7:0] scb(int h, int v, int f); return 8'((h*37 + v*11 + f*5 + 64) % 256);  endfunction
    function automatic logic [7:0] scr(int h, int v, int f); return 8'((h*23 + v*17 + f*9 + 150) % 256); endfunction
    function automatic logic [7:0] sr(int h, int v, int f);  return 8'((h*41 + v*3 + f + 200) % 256);    endfunction
    function automatic logic [7:0] sg(int h, int v, int f);  return 8'((h*19 + v*53 + f*2 + 7) % 256);   endfunction
    function automatic logic [7:0] sb(int h, int v, int f);  return 8'((h*31 + v*7 + f*3 + 90) % 256);   endfunction

    function automatic logic [7:0] code_byte(int idx, int f, logic vb, logic hh);
        logic ff;
        ff = (f != 0);
        if (idx == 0) return 8'hFF;
        if (idx == 3) return {1'b1, ff, vb, hh, vb ^ hh, ff ^ hh, ff ^ vb, ff ^ vb ^ hh};
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_word(int m, int h, int v, int f);
        logic hb, vb, act;
        logic [7:0] y, cb, cr, r, g, b, bt;
        hb = (h >= HBS) || (h < HBE);
        vb = (v >= VBS) || (v < VBE);
        act = !hb && !vb;
        y = sy(h, v, f); cb = scb(h, v, f); cr = scr(h, v, f);
        r = sr(h, v, f); g = sg(h, v, f); b = sb(h, v, f);
        case (m)
            0: return act ? {y, (((h - HBE) % 2) == 1) ? cr : cb} : 16'h1080;
            1: return act ? {r[7:3], g[7:2], b[7:3]} : 16'h0000;
            2: return act ? {1'b0, r[7:3], g[7:3], b[7:3]} : 16'h0000;
            default: begin
                if (h >= HBS && h < HBS + 4)       bt = code_byte(h - HBS, f, vb, 1'b1);
                else if (h >= HBE - 4 && h < HBE)  bt = code_byte(h - (HBE - 4), f, vb, 1'b0);
                else if (act) begin
                    case ((h - HBE) % 4)
                        0:       bt = cb;
                        2:       bt = cr;
                        default: bt = y;
                    endcase
                end else bt = ((h % 2) == 1) ? 8'h10 : 8'h80;
                return {8'h00, bt};
            end
        endcase
    endfunction

    function automatic string tag_of(int m, int h, int v);
        logic hb, vb;
        hb = (h >= HBS) || (h < HBE);
        vb = (v >= VBS) || (v < VBE);
        if (m == 3 && ((h >= HBS && h < HBS + 4) || (h >= HBE - 4 && h < HBE))) return "R4,R8";
        if (hb || vb) return "R5,R8";
        if (m == 0) return "R1,R8";
        if (m == 3) return "R3,R8";
        return "R2,R8";
    endfunction

    // drive one valid pixel at the current falling edge, check one cycle later
    task automatic send_pix(int m, int h, int v, int f);
        logic hb, vb;
        in_vld   = 1'b1;
        in_sol   = (h == 0);
        in_sof   = (h == 0) && (v == 0);
        in_field = (f != 0);
        fmt_i    = (h == 0) ? 2'(m) : 2'(m ^ 2);   // R8: mid-line requests must be ignored
        in_y  = sy(h, v, f);  in_cb = scb(h, v, f); in_cr = scr(h, v, f);
        in_r  = sr(h, v, f);  in_g  = sg(h, v, f);  in_b  = sb(h, v, f);
        @(negedge clk);
        hb = (h >= HBS) || (h < HBE);
        vb = (v >= VBS) || (v < VBE);
        chk("R7 dvalid", 32'(dvalid_o), 32'd1);
        chk(tag_of(m, h, v), 32'(pix_o), 32'(exp_word(m, h, v, f)));
        chk("R6 hsync", 32'(hsync_o), 32'(hb));
        chk("R6 vsync", 32'(vsync_o), 32'(vb));
        chk("R6 blank", 32'(blank_o), 32'(hb || vb));
        chk("R6 field", 32'(field_o), 32'(f));
        last_pix   = pix_o;
        last_blank = blank_o;
    endtask

    // idle strobe with stray flags and data: nothing may change
    task automatic send_gap(int seed);
        in_vld   = 1'b0;
        in_sol   = 1'b1;
        in_sof   = 1'b1;
        in_field = ~in_field;
        fmt_i    = 2'(seed);
        in_y = 8'(seed * 3); in_cb = 8'(seed * 5); in_cr = 8'(seed * 7);
        in_r = 8'(seed * 9); in_g = 8'(seed * 11); in_b = 8'(seed * 13);
        @(negedge clk);
        chk("R7 dvalid low", 32'(dvalid_o), 32'd0);
        chk("R7 pix hold", 32'(pix_o), 32'(last_pix));
        chk("R7 blank hold", 32'(blank_o), 32'(last_blank));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_vld = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_field = 1'b0;
        fmt_i = 2'd3;
        in_y = '0; in_cb = '0; in_cr = '0; in_r = '0; in_g = '0; in_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset values seen before any pixel
        chk("R9 pix", 32'(pix_o), 32'h1080);
        chk("R9 blank", 32'(blank_o), 32'd1);
        chk("R9 dvalid", 32'(dvalid_o), 32'd0);
        chk("R9 hsync", 32'(hsync_o), 32'd0);
        chk("R9 vsync", 32'(vsync_o), 32'd0);
        chk("R9 field", 32'(field_o), 32'd0);

        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int v = 0; v < VLEN; v++) begin
                    for (int h = 0; h < HLEN; h++) begin
                        send_pix(m, h, v, f);
                        if (((h * 5 + v + m) % 7) == 3) send_gap(h + v);
                        if (((h + v * 3 + f) % 11) == 6) begin
                            send_gap(h * 2 + 1);
                            send_gap(h * 3 + 2);
                        end
                    end
                end
            end
        end

        in_vld = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule